// File: doc/BRIEF.md
# Byte-Level Register Bank with Auto-Incrementing Pointer

This block is the register-access layer for a small two-channel LED blinker controlled over a byte-oriented serial bus. A front end decodes start, stop and bit shifting. It hands this block one event per cycle: an address byte, a written data byte, a read request or a stop. The block matches the address and keeps the session state. It stores a control byte that holds a register pointer and an auto-increment flag, and it moves data between the bus and a bank of six byte registers. It returns a registered acknowledge, and for reads a data byte, in the cycle after each event.

The bank has one read-only register that samples the two LED pin levels. It also has two period prescalers, two duty registers and one output-select register. The five writable registers drive a flat configuration bus that feeds the blink generators downstream. When auto-increment is on, the pointer steps through the implemented registers and wraps to zero after the last one, not at a power of two.

Top module: `led_regbank`

## Requirements
- R1: An address byte matches when bits 7:1 equal `1100 00` followed by `addr_strap`. Bit 0 selects the direction: 1 is read, 0 is write. A matching address is acknowledged, and a non-matching one is not.
- R2: After a non-matching address, later write and read events get no acknowledge and no read data, and they change no register until the next address event.
- R3: The first write byte after a matching write address is the control byte. It is acknowledged, and it loads the auto-increment flag from bit 4 and the pointer from bits 2:0. Other bits are ignored. After reset the flag and the pointer are zero.
- R4: Each later write byte is acknowledged and is stored in the register the pointer selects: 1 = prescaler 0, 2 = duty 0, 3 = prescaler 1, 4 = duty 1, 5 = output select. `cfg_flat` carries register k in bits 8k-1:8k-8.
- R5: With auto-increment set, the pointer advances by one after each data write or read. From 5 it wraps to 0, and from 6 or 7 it also goes to 0.
- R6: With auto-increment clear, the pointer stays the same across consecutive data bytes.
- R7: A data write to pointer 0 is acknowledged and changes nothing.
- R8: A read at pointer 0 returns the two LED pin levels in bits 1:0 and zeros in bits 7:2.
- R9: Pointers 6 and 7 read back as 00h. Writes to them are acknowledged and ignored.
- R10: After reset, both prescalers hold FFh, both duty registers hold 80h and output select holds F5h.
- R11: A read request in a matched read session gives `resp_rd_valid` and `resp_ack` high for one cycle, in the cycle after the request, with the data. A read request in a write session, or a write in a read session, gets no response.
- R12: A stop event ends the session. Later data events get no response until a new matching address arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_strap | input | 1 | Strap value for the selectable address bit |
| ev_valid | input | 1 | One byte-level event is present this cycle |
| ev_kind | input | 2 | Event type: 0 address, 1 write byte, 2 read request, 3 stop |
| ev_data | input | 8 | Address byte or written data byte |
| led_level | input | 2 | Current levels of the two LED pins |
| resp_ack | output | 1 | Acknowledge for the event of the previous cycle |
| resp_rd_valid | output | 1 | Read data is valid |
| resp_rd_data | output | 8 | Read data byte, zero when not valid |
| cfg_flat | output | 40 | Writable registers 1 to 5, register k in byte k-1 |

## Verification
The assertions check, on every cycle, the properties that concern a single event. A write to pointer 0, 6 or 7 must leave the configuration bus unchanged. Data events outside a session must get no acknowledge. The pointer must hold when auto-increment is clear and must wrap after register 5. The control byte must load the flag and the pointer, and reads of pointer 0 must return the pin levels. The reset defaults are checked when reset is released. Only the bench's scenarios can show the effects that build up over many events: a burst that fills registers 1 to 5 and then wraps to register 0, where the write is dropped. They also cover read-back of earlier writes after a new address, strap changes, and long random mixes of matched and unmatched sessions compared against a model.

// File: rtl/ledbank_pkg.sv
package ledbank_pkg;

  localparam int BYTE_W = 8;
  localparam int PTR_W  = 3;

  typedef enum logic [1:0] {
    EV_ADDR  = 2'd0,
    EV_WRITE = 2'd1,
    EV_READ  = 2'd2,
    EV_STOP  = 2'd3
  } ev_kind_e;

  // Reset value of register idx: last is output select, odd are prescalers,
  // remaining are duty registers.
  function automatic logic [BYTE_W-1:0] reg_default(input int idx, input int nregs);
    if (idx == nregs - 1) return 8'hF5;
    if ((idx % 2) == 1)   return 8'hFF;
    return 8'h80;
  endfunction

  // Next pointer value under auto-increment; wraps after last implemented reg.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p, input int nregs);
    if (int'(p) >= nregs - 1) return '0;
    return p + PTR_W'(1);
  endfunction

endpackage

// File: rtl/ledbank_addr_match.sv
module ledbank_addr_match
  import ledbank_pkg::*;
#(
  parameter logic [5:0] FIXED_BITS = 6'b110000
) (
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              strap,
  output logic              hit,
  output logic              is_read
);

  logic [6:0] own_addr;

  assign own_addr = {FIXED_BITS, strap};
  assign hit      = (addr_byte[7:1] == own_addr);
  assign is_read  = addr_byte[0];

endmodule

// File: rtl/ledbank_session.sv
module ledbank_session
  import ledbank_pkg::*;
#(
  parameter int NREGS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_ev,
  input  logic             wr_ev,
  input  logic             rd_ev,
  input  logic             stop_ev,
  input  logic             addr_hit,
  input  logic             addr_is_read,
  input  logic             ctrl_ai_bit,
  input  logic [PTR_W-1:0] ctrl_ptr_bits,
  output logic             sel,
  output logic             ai,
  output logic [PTR_W-1:0] ptr,
  output logic             ctrl_load,
  output logic             wr_commit,
  output logic             rd_commit,
  output logic             ptr_adv
);

  logic dir_rd;
  logic expect_ctrl;
  logic wr_ok;

  assign wr_ok     = wr_ev && sel && !dir_rd;
  assign ctrl_load = wr_ok && expect_ctrl;
  assign wr_commit = wr_ok && !expect_ctrl;
  assign rd_commit = rd_ev && sel && dir_rd;
  assign ptr_adv   = (wr_commit || rd_commit) && ai;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel         <= 1'b0;
      dir_rd      <= 1'b0;
      expect_ctrl <= 1'b0;
    end else if (addr_ev) begin
      sel         <= addr_hit;
      dir_rd      <= addr_is_read;
      expect_ctrl <= addr_hit && !addr_is_read;
    end else if (stop_ev) begin
      sel         <= 1'b0;
      expect_ctrl <= 1'b0;
    end else if (ctrl_load) begin
      expect_ctrl <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ai  <= 1'b0;
      ptr <= '0;
    end else if (ctrl_load) begin
      ai  <= ctrl_ai_bit;
      ptr <= ctrl_ptr_bits;
    end else if (ptr_adv) begin
      ptr <= ptr_step(ptr, NREGS);
    end
  end

endmodule

// File: rtl/ledbank_regfile.sv
module ledbank_regfile
  import ledbank_pkg::*;
#(
  parameter int NREGS = 6,
  parameter int LED_N = 2,
  localparam int CFG_W = (NREGS - 1) * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [LED_N-1:0]  led_level,
  output logic [BYTE_W-1:0] rdata,
  output logic [CFG_W-1:0]  cfg_flat
);

  logic [BYTE_W-1:0] store [1:NREGS-1];

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= reg_default(g, NREGS);
      else if (wr_en && (ptr == PTR_W'(g)))    q <= wdata;
    end
    assign store[g] = q;
    assign cfg_flat[(g-1)*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rdata = '0;
    if (ptr == '0) rdata[LED_N-1:0] = led_level;
    for (int i = 1; i < NREGS; i++) begin
      if (ptr == PTR_W'(i)) rdata = store[i];
    end
  end

endmodule

// File: rtl/led_regbank.sv
module led_regbank
  import ledbank_pkg::*;
#(
  parameter int         NREGS      = 6,
  parameter int         LED_N      = 2,
  parameter logic [5:0] FIXED_BITS = 6'b110000,
  localparam int        CFG_W      = (NREGS - 1) * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_strap,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [BYTE_W-1:0] ev_data,
  input  logic [LED_N-1:0]  led_level,
  output logic              resp_ack,
  output logic              resp_rd_valid,
  output logic [BYTE_W-1:0] resp_rd_data,
  output logic [CFG_W-1:0]  cfg_flat
);

  ev_kind_e kind;
  logic addr_ev, wr_ev, rd_ev, stop_ev;
  logic addr_hit, addr_is_read;
  logic sel, ai;
  logic [PTR_W-1:0] ptr;
  logic ctrl_load, wr_commit, rd_commit, ptr_adv;
  logic [BYTE_W-1:0] rdata;

  assign kind    = ev_kind_e'(ev_kind);
  assign addr_ev = ev_valid && (kind == EV_ADDR);
  assign wr_ev   = ev_valid && (kind == EV_WRITE);
  assign rd_ev   = ev_valid && (kind == EV_READ);
  assign stop_ev = ev_valid && (kind == EV_STOP);

  ledbank_addr_match #(.FIXED_BITS(FIXED_BITS)) u_match (
    .addr_byte (ev_data),
    .strap     (addr_strap),
    .hit       (addr_hit),
    .is_read   (addr_is_read)
  );

  ledbank_session #(.NREGS(NREGS)) u_sess (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_ev       (addr_ev),
    .wr_ev         (wr_ev),
    .rd_ev         (rd_ev),
    .stop_ev       (stop_ev),
    .addr_hit      (addr_hit),
    .addr_is_read  (addr_is_read),
    .ctrl_ai_bit   (ev_data[4]),
    .ctrl_ptr_bits (ev_data[PTR_W-1:0]),
    .sel           (sel),
    .ai            (ai),
    .ptr           (ptr),
    .ctrl_load     (ctrl_load),
    .wr_commit     (wr_commit),
    .rd_commit     (rd_commit),
    .ptr_adv       (ptr_adv)
  );

  ledbank_regfile #(.NREGS(NREGS), .LED_N(LED_N)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_commit),
    .ptr       (ptr),
    .wdata     (ev_data),
    .led_level (led_level),
    .rdata     (rdata),
    .cfg_flat  (cfg_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_ack      <= 1'b0;
      resp_rd_valid <= 1'b0;
      resp_rd_data  <= '0;
    end else begin
      resp_ack      <= (addr_ev && addr_hit) || ctrl_load || wr_commit || rd_commit;
      resp_rd_valid <= rd_commit;
      resp_rd_data  <= rd_commit ? rdata : '0;
    end
  end

endmodule

// File: rtl/ledbank_chk.sv
module ledbank_chk
  import ledbank_pkg::*;
#(
  parameter int NREGS = 6,
  parameter int LED_N = 2,
  localparam int CFG_W = (NREGS - 1) * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic [1:0]        ev_kind,
  input logic [BYTE_W-1:0] ev_data,
  input logic [LED_N-1:0]  led_level,
  input logic              resp_ack,
  input logic              resp_rd_valid,
  input logic [BYTE_W-1:0] resp_rd_data,
  input logic [CFG_W-1:0]  cfg_flat,
  input logic              sel,
  input logic              ai,
  input logic [PTR_W-1:0]  ptr,
  input logic              ctrl_load,
  input logic              wr_commit,
  input logic              rd_commit,
  input logic              ptr_adv
);

  function automatic logic [CFG_W-1:0] all_defaults();
    logic [CFG_W-1:0] v;
    for (int i = 1; i < NREGS; i++) v[(i-1)*BYTE_W +: BYTE_W] = reg_default(i, NREGS);
    return v;
  endfunction

  localparam logic [CFG_W-1:0] DEF_CFG = all_defaults();

  // R10
  reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_flat == DEF_CFG);

  // R7
  input_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && ptr == '0) |=> $stable(cfg_flat));

  // R9
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && int'(ptr) >= NREGS) |=> $stable(cfg_flat));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_commit || rd_commit) && !ai) |=> $stable(ptr));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && int'(ptr) == NREGS - 1) |=> ptr == '0);

  // R2
  no_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind != 2'd0 && !sel) |=> (!resp_ack && $stable(cfg_flat)));

  // R3
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_load |=> (ptr == $past(ev_data[PTR_W-1:0]) && ai == $past(ev_data[4])));

  // R8
  input_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_commit && ptr == '0) |=> resp_rd_data == {{(BYTE_W-LED_N){1'b0}}, $past(led_level)});

  // R11
  read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_rd_valid |-> resp_ack);

endmodule

bind led_regbank ledbank_chk #(.NREGS(NREGS), .LED_N(LED_N)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_valid      (ev_valid),
  .ev_kind       (ev_kind),
  .ev_data       (ev_data),
  .led_level     (led_level),
  .resp_ack      (resp_ack),
  .resp_rd_valid (resp_rd_valid),
  .resp_rd_data  (resp_rd_data),
  .cfg_flat      (cfg_flat),
  .sel           (sel),
  .ai            (ai),
  .ptr           (ptr),
  .ctrl_load     (ctrl_load),
  .wr_commit     (wr_commit),
  .rd_commit     (rd_commit),
  .ptr_adv       (ptr_adv)
);

// File: tb/led_regbank_test.sv
module led_regbank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_strap = 1'b0;
  logic        ev_valid = 1'b0;
  logic [1:0]  ev_kind = 2'd0;
  logic [7:0]  ev_data = 8'h00;
  logic [1:0]  led_level = 2'b10;
  logic        resp_ack;
  logic        resp_rd_valid;
  logic [7:0]  resp_rd_data;
  logic [39:0] cfg_flat;

  int checks = 0;
  int errors = 0;

  // model state
  logic [7:0] m_reg [0:7];
  logic       m_sel, m_rd, m_need_ctrl, m_ai;
  logic [2:0] m_ptr;

  led_regbank uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_strap    (addr_strap),
    .ev_valid      (ev_valid),
    .ev_kind       (ev_kind),
    .ev_data       (ev_data),
    .led_level     (led_level),
    .resp_ack      (resp_ack),
    .resp_rd_valid (resp_rd_valid),
    .resp_rd_data  (resp_rd_data),
    .cfg_flat      (cfg_flat)
  );

  always #5 clk = ~clk;

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [2:0] next_ptr(input logic [2:0] p);
    if (p <= 3'd5) return 3'((int'(p) + 1) % 6);
    return 3'd0;
  endfunction

  function automatic logic [39:0] model_cfg();
    return {m_reg[5], m_reg[4], m_reg[3], m_reg[2], m_reg[1]};
  endfunction

  function automatic logic [7:0] model_read(input logic [2:0] p);
    if (p == 3'd0) return {6'b0, led_level};
    if (p >= 3'd6) return 8'h00;
    return m_reg[p];
  endfunction

  task automatic model_reset();
    m_reg[0] = 8'h00; m_reg[1] = 8'hFF; m_reg[2] = 8'h80; m_reg[3] = 8'hFF;
    m_reg[4] = 8'h80; m_reg[5] = 8'hF5; m_reg[6] = 8'h00; m_reg[7] = 8'h00;
    m_sel = 0; m_rd = 0; m_need_ctrl = 0; m_ai = 0; m_ptr = 3'd0;
  endtask

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive one event, update the model, check the response one cycle later.
  task automatic send(input string tag, input logic [1:0] kind, input logic [7:0] data);
    logic       e_ack = 1'b0;
    logic       e_rv  = 1'b0;
    logic [7:0] e_rd  = 8'h00;
    ev_valid = 1'b1; ev_kind = kind; ev_data = data;
    case (kind)
      2'd0: begin
        m_sel = (data[7:1] == {6'b110000, addr_strap});
        m_rd = data[0];
        m_need_ctrl = m_sel && !data[0];
        e_ack = m_sel;
      end
      2'd1: if (m_sel && !m_rd) begin
        e_ack = 1'b1;
        if (m_need_ctrl) begin
          m_need_ctrl = 0; m_ai = data[4]; m_ptr = data[2:0];
        end else begin
          if (m_ptr >= 3'd1 && m_ptr <= 3'd5) m_reg[m_ptr] = data;
          if (m_ai) m_ptr = next_ptr(m_ptr);
        end
      end
      2'd2: if (m_sel && m_rd) begin
        e_ack = 1'b1; e_rv = 1'b1; e_rd = model_read(m_ptr);
        if (m_ai) m_ptr = next_ptr(m_ptr);
      end
      default: begin m_sel = 0; m_need_ctrl = 0; end
    endcase
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    check(tag, "ack", 64'(resp_ack), 64'(e_ack));
    check(tag, "rd_valid", 64'(resp_rd_valid), 64'(e_rv));
    check(tag, "rd_data", 64'(resp_rd_data), 64'(e_rd));
    check(tag, "cfg", 64'(cfg_flat), 64'(model_cfg()));
  endtask

  function automatic logic [7:0] waddr(input logic rd);
    return {6'b110000, addr_strap, rd};
  endfunction

  initial begin
    model_reset();
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset defaults
    check("R10", "cfg reset", 64'(cfg_flat), 64'h00F580FF80FF);
    check("R10", "ack reset", 64'(resp_ack), 64'd0);

    // R3 / R5 / R7 burst from register 1 with auto-increment, wraps to 0
    send("R1", 2'd0, waddr(1'b0));
    send("R3", 2'd1, 8'h11);
    send("R4", 2'd1, 8'h0A);
    send("R4", 2'd1, 8'h1B);
    send("R4", 2'd1, 8'h2C);
    send("R4", 2'd1, 8'h3D);
    send("R5", 2'd1, 8'h4E);
    send("R7", 2'd1, 8'h5F);
    check("R7", "regs after wrap", 64'(cfg_flat), 64'h4E3D2C1B0A);
    send("R5", 2'd1, 8'h66);
    check("R5", "reg1 after wrap", 64'(cfg_flat[7:0]), 64'h66);
    send("R12", 2'd3, 8'h00);
    send("R12", 2'd1, 8'h77);

    // R8 / R11 reads from pointer 0 in a read session
    send("R1", 2'd0, waddr(1'b1));
    led_level = 2'b01;
    send("R8", 2'd2, 8'h00);
    send("R11", 2'd2, 8'h00);
    send("R11", 2'd1, 8'h12);
    send("R12", 2'd3, 8'h00);

    // R6 pointer fixed without auto-increment
    send("R1", 2'd0, waddr(1'b0));
    send("R3", 2'd1, 8'h04);
    send("R6", 2'd1, 8'hA1);
    send("R6", 2'd1, 8'hA2);
    check("R6", "duty1", 64'(cfg_flat[31:24]), 64'hA2);
    send("R1", 2'd0, waddr(1'b1));
    send("R6", 2'd2, 8'h00);
    send("R6", 2'd2, 8'h00);

    // R9 unmapped pointers
    send("R1", 2'd0, waddr(1'b0));
    send("R3", 2'd1, 8'h16);
    send("R9", 2'd1, 8'hEE);
    send("R9", 2'd1, 8'hDD);
    send("R1", 2'd0, waddr(1'b0));
    send("R3", 2'd1, 8'h07);
    send("R1", 2'd0, waddr(1'b1));
    send("R9", 2'd2, 8'h00);

    // R2 mismatched address, R1 strap change
    send("R1", 2'd0, 8'hC4);
    send("R2", 2'd1, 8'h01);
    send("R2", 2'd1, 8'h99);
    send("R2", 2'd2, 8'h00);
    addr_strap = 1'b1;
    send("R1", 2'd0, 8'hC0);
    send("R2", 2'd1, 8'h55);
    send("R1", 2'd0, 8'hC2);
    send("R3", 2'd1, 8'h15);
    send("R4", 2'd1, 8'hC3);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      if (n % 97 == 0) addr_strap = ~addr_strap;
      if (n % 13 == 0) led_level = 2'($urandom);
      if (sel < 2) begin
        if ($urandom_range(0, 3) == 0) send("R1", 2'd0, d);
        else send("R1", 2'd0, waddr(d[0]));
      end else if (sel < 6) begin
        send("R4", 2'd1, d);
      end else if (sel < 9) begin
        send("R11", 2'd2, 8'h00);
      end else begin
        send("R12", 2'd3, 8'h00);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule